// File: doc/BRIEF.md
# Software Store Unlock Sequence Detector

This block watches decoded accesses on an SRAM bus and picks out a software command that asks for the memory contents to be saved to nonvolatile storage. An access is qualified by a valid strobe and three active-low controls: chip enable, output enable and write enable. A command is six reads in a row, each from its own address. The six addresses are set by a parameter array. When the sixth read in order is accepted, the block raises a one-cycle request to the store sequencer.

If any write, or a read from an address other than the one expected next, comes between the trigger reads, the partial match is dropped and no request is made. After a request, the detector ignores the bus until the store logic has raised and then dropped its busy flag. A power-fail flag clears all progress and any lockout.

Top module: `sw_store_unlock`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, store_req_o is low and no partial match is held.
- R2: A valid access is a read only when ce_n_i=0, oe_n_i=0 and we_n_i=1. A read whose address is the next expected trigger address advances the match by one step.
- R3: A valid access with ce_n_i=0 and we_n_i=0 is a write, whatever oe_n_i is. A write drops any partial match back to zero.
- R4: Six accepted reads from trigger addresses 0 through 5, in that order, drive store_req_o high for exactly one cycle. The pulse starts in the cycle after the clock edge that samples the sixth read.
- R5: A read from any address other than the expected one aborts the match. If that read's address is trigger address 0, the match restarts at step one instead of zero.
- R6: These leave the match unchanged: cycles with acc_valid_i=0, and valid cycles that are neither a read nor a write (ce_n_i=1, or ce_n_i=0 with oe_n_i=1 and we_n_i=1).
- R7: After a request, accesses are ignored until busy_i has been high and then goes low. Accesses are also ignored in any cycle where busy_i is high.
- R8: pwr_fail_i high clears the match and the lockout at the next edge. It also suppresses any request in that cycle.
- R9: Writes made before a complete command do not stop the request. The request does not depend on prior write activity.
- R10: The trigger addresses are matched in order only. The same six reads in any other order give no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One bus access is present this cycle |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Access address |
| busy_i | input | 1 | Store sequencer busy |
| pwr_fail_i | input | 1 | Power-fail flag; clears the detector |
| store_req_o | output | 1 | One-cycle software store request |

## Verification
The bench first runs a clean six-read command, then runs the same addresses broken up in different ways. A write in the middle, with output enable low, separates a real write from a read. A stray read separates an abort from a restart on trigger address 0. Non-access cycles and output-enable-high cycles are inserted to show they neither abort nor advance the match. A permuted order shows that the addresses are matched in order. Further runs are made while busy is held, after a request without a busy handshake, and around a power-fail pulse. These show when the lockout starts and ends, and that power-fail takes priority over a request due in the same cycle.

// File: rtl/sw_store_pkg.sv
package sw_store_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sw_store_acc_decode.sv
module sw_store_acc_decode
  import sw_store_pkg::*;
(
  input  logic      valid_i,
  input  logic      ce_n_i,
  input  logic      oe_n_i,
  input  logic      we_n_i,
  output acc_kind_e kind_o
);
  always_comb begin
    kind_o = ACC_NONE;
    if (valid_i && !ce_n_i) begin
      if (!we_n_i)      kind_o = ACC_WRITE; // write wins regardless of oe
      else if (!oe_n_i) kind_o = ACC_READ;
    end
  end
endmodule

// File: rtl/sw_store_addr_match.sv
module sw_store_addr_match #(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned SEQ_LEN = 6,
  parameter logic [ADDR_W-1:0] SEQ_ADDR [SEQ_LEN] = '{
    15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0}
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [SEQ_LEN-1:0] hit_o
);
  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_cmp
    assign hit_o[k] = (addr_i == SEQ_ADDR[k]);
  end
endmodule

// File: rtl/sw_store_seq_track.sv
module sw_store_seq_track #(
  parameter int unsigned SEQ_LEN = 6,
  localparam int unsigned CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [SEQ_LEN-1:0] hit_i,
  output logic               fire_o,
  output logic [CNT_W-1:0]   prog_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] prog_q, prog_d;
  logic             hit_cur;
  logic             fire;

  assign hit_cur = hit_i[prog_q];

  always_comb begin
    prog_d = prog_q;
    fire   = 1'b0;
    if (en_i) begin
      if (wr_i) begin
        prog_d = '0;
      end else if (rd_i) begin
        if (hit_cur) begin
          if (prog_q == LAST) begin
            fire   = 1'b1;
            prog_d = '0;
          end else begin
            prog_d = prog_q + ONE;
          end
        end else if (hit_i[0]) begin
          prog_d = ONE; // stray read of first address restarts at step one
        end else begin
          prog_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prog_q <= '0;
    else if (clr_i) prog_q <= '0;
    else            prog_q <= prog_d;
  end

  assign fire_o = fire & ~clr_i;
  assign prog_o = prog_q;

  a_r5_prog_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_q <= LAST);
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(prog_q));
  a_r3_write_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> (prog_q == '0));
  a_r8_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (prog_q == '0));
endmodule

// File: rtl/sw_store_unlock.sv
module sw_store_unlock
  import sw_store_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned SEQ_LEN = 6,
  parameter logic [ADDR_W-1:0] SEQ_ADDR [SEQ_LEN] = '{
    15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              pwr_fail_i,
  output logic              store_req_o
);
  localparam int unsigned CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  acc_kind_e          kind;
  logic [SEQ_LEN-1:0] hit;
  logic [CNT_W-1:0]   prog;
  logic               fire;
  logic               locked_q, busy_q, req_q;
  logic               busy_fall, ignore;

  sw_store_acc_decode u_dec (
    .valid_i (acc_valid_i),
    .ce_n_i  (ce_n_i),
    .oe_n_i  (oe_n_i),
    .we_n_i  (we_n_i),
    .kind_o  (kind)
  );

  sw_store_addr_match #(
    .ADDR_W   (ADDR_W),
    .SEQ_LEN  (SEQ_LEN),
    .SEQ_ADDR (SEQ_ADDR)
  ) u_match (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign busy_fall = busy_q & ~busy_i;
  assign ignore    = locked_q | busy_i;

  sw_store_seq_track #(
    .SEQ_LEN (SEQ_LEN)
  ) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pwr_fail_i),
    .en_i   (~ignore),
    .rd_i   (kind == ACC_READ),
    .wr_i   (kind == ACC_WRITE),
    .hit_i  (hit),
    .fire_o (fire),
    .prog_o (prog)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      busy_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      busy_q <= busy_i;
      req_q  <= fire;
      if (pwr_fail_i)     locked_q <= 1'b0;
      else if (fire)      locked_q <= 1'b1;
      else if (busy_fall) locked_q <= 1'b0;
    end
  end

  assign store_req_o = req_q;

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  a_r4_req_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> locked_q);
  a_r4_req_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> ($past(prog) == CNT_W'(SEQ_LEN - 1)));
  a_r7_locked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q || busy_i) |=> !store_req_o);
  a_r8_pf_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> (!store_req_o && !locked_q));
endmodule

// File: tb/sw_store_unlock_tb_top.sv
`timescale 1ns/1ps
module sw_store_unlock_tb_top;
  localparam logic [14:0] TB_SEQ [6] = '{
    15'h1A5A, 15'h2C33, 15'h0777, 15'h3E01, 15'h1248, 15'h0F0F};
  localparam logic [14:0] OTHER = 15'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic        busy = 1'b0, pf = 1'b0;
  logic        req;

  int total = 0;
  int bad = 0;
  int req_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sw_store_unlock #(
    .ADDR_W (15), .SEQ_LEN (6), .SEQ_ADDR (TB_SEQ)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .acc_valid_i (valid),
    .ce_n_i (ce_n), .oe_n_i (oe_n), .we_n_i (we_n), .addr_i (addr),
    .busy_i (busy), .pwr_fail_i (pf), .store_req_o (req)
  );

  always @(negedge clk) if (req) req_cnt++;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic bus(input logic v, input logic c, input logic o,
                     input logic w, input logic [14:0] a);
    @(negedge clk);
    valid = v; ce_n = c; oe_n = o; we_n = w; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [14:0] a);  bus(1, 0, 0, 1, a); endtask
  task automatic wr(input logic [14:0] a, input logic o); bus(1, 0, o, 0, a); endtask
  task automatic idle();                     bus(0, 1, 1, 1, '0); endtask

  task automatic seq(input int from, input int to);
    for (int k = from; k <= to; k++) rd(TB_SEQ[k]);
  endtask

  task automatic release_lock();
    busy = 1'b1; idle();
    busy = 1'b0; idle();
  endtask

  task automatic t_reset();
    chk("R1 req low in reset", int'(req), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 req low after reset", int'(req), 0);
  endtask

  task automatic t_full();
    int b = req_cnt;
    seq(0, 5);
    chk("R4 req right after sixth read", int'(req), 1);
    idle();
    chk("R4 req drops after one cycle", int'(req), 0);
    idle();
    chk("R2 R4 one pulse per command", req_cnt - b, 1);
    release_lock();
  endtask

  task automatic t_write_abort();
    int b = req_cnt;
    seq(0, 2); wr(TB_SEQ[3], 1'b0); seq(3, 5); idle(); idle();
    chk("R3 write with oe low aborts", req_cnt - b, 0);
  endtask

  task automatic t_wrong_read();
    int b = req_cnt;
    seq(0, 1); rd(OTHER); seq(2, 5); idle(); idle();
    chk("R5 wrong address aborts", req_cnt - b, 0);
  endtask

  task automatic t_restart();
    int b = req_cnt;
    seq(0, 1); rd(TB_SEQ[0]); seq(1, 5); idle(); idle();
    chk("R5 restart at step one", req_cnt - b, 1);
    release_lock();
  endtask

  task automatic t_neutral();
    int b = req_cnt;
    seq(0, 2);
    bus(1, 1, 0, 0, OTHER);       // chip not enabled
    bus(1, 0, 1, 1, OTHER);       // output enable high, no write
    bus(0, 0, 0, 0, OTHER);       // valid low
    seq(3, 5); idle(); idle();
    chk("R6 non-accesses do not abort", req_cnt - b, 1);
    release_lock();
    b = req_cnt;
    seq(0, 4);
    bus(1, 0, 1, 1, TB_SEQ[5]);   // oe high: not a read
    idle();
    chk("R2 R6 oe-high access does not advance", req_cnt - b, 0);
    rd(TB_SEQ[5]); idle(); idle();
    chk("R6 progress kept at step five", req_cnt - b, 1);
    release_lock();
  endtask

  task automatic t_busy_lock();
    int b = req_cnt;
    busy = 1'b1;
    seq(0, 5); idle(); idle();
    chk("R7 ignored while busy high", req_cnt - b, 0);
    busy = 1'b0; idle();
    seq(0, 5); idle(); idle();
    chk("R7 accepted when not busy", req_cnt - b, 1);
    b = req_cnt;
    seq(0, 5); idle(); idle();
    chk("R7 locked until busy falls", req_cnt - b, 0);
    release_lock();
    seq(0, 5); idle(); idle();
    chk("R7 lock released by busy fall", req_cnt - b, 1);
    release_lock();
  endtask

  task automatic t_pwr_fail();
    int b = req_cnt;
    seq(0, 2);
    pf = 1'b1; idle(); pf = 1'b0;
    seq(3, 5); idle(); idle();
    chk("R8 power fail clears progress", req_cnt - b, 0);
    seq(0, 4);
    @(negedge clk);
    valid = 1; ce_n = 0; oe_n = 0; we_n = 1; addr = TB_SEQ[5]; pf = 1'b1;
    @(posedge clk); #1;
    pf = 1'b0;
    idle(); idle();
    chk("R8 power fail suppresses request", req_cnt - b, 0);
    seq(0, 5); idle();
    chk("R8 request after power fail", req_cnt - b, 1);
    pf = 1'b1; idle(); pf = 1'b0;
    seq(0, 5); idle(); idle();
    chk("R8 power fail clears lockout", req_cnt - b, 2);
    release_lock();
  endtask

  task automatic t_no_write_dep();
    int b = req_cnt;
    wr(OTHER, 1'b1); wr(TB_SEQ[0], 1'b1); seq(0, 5); idle(); idle();
    chk("R9 request regardless of prior writes", req_cnt - b, 1);
    release_lock();
  endtask

  task automatic t_order();
    int b = req_cnt;
    rd(TB_SEQ[0]); rd(TB_SEQ[2]); rd(TB_SEQ[1]);
    seq(3, 5); idle(); idle();
    chk("R10 swapped order gives no request", req_cnt - b, 0);
    for (int k = 5; k >= 0; k--) rd(TB_SEQ[k]);
    idle(); idle();
    chk("R10 reverse order gives no request", req_cnt - b, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_full();
    t_write_abort();
    t_wrong_read();
    t_restart();
    t_neutral();
    t_busy_lock();
    t_pwr_fail();
    t_no_write_dep();
    t_order();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule